// File: doc/BRIEF.md
# Direct-Mapped L1 Tag Controller

This block is the hardware side of a direct-mapped level-1 data cache whose lines are very large: each line holds a complete 128-word block of the next cache level. A tag store keeps, for every line, the upper address bits, a valid bit and a modified bit. A line-data RAM inside the block holds the words. The processor side presents a word address every cycle. Whenever that address differs from the one seen in the previous cycle, the block raises a one-cycle evaluation strobe together with the hit result. Writes that hit are stored and mark the line modified. Writes that miss are dropped.

Line refills arrive as a valid/ready word stream after a fill request. The stream fills the line in offset order and commits the new tag on its last word. On a miss, the block shows whether the resident line is modified and what its tag is, so that software can write it back before it refills. A flush command walks every line in index order. It offers each valid line on a valid/ready report stream. An initialize input clears all tag state and the hit indication.

Back-pressure rules: a fill word transfers on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` drops in any cycle in which a processor write hits, because that write owns the single RAM write port. A report transfers on a clock edge where `rep_valid` and `rep_ready` are both high. While `rep_ready` is low, the report is held unchanged.

Top module: `l1_tag_ctrl`

## Requirements
- R1: The word address splits as follows. Bits [6:0] are the word offset inside the line. The next IDX_W bits (default 2, giving 4 lines) are the line index. The remaining upper bits (default 7) are the tag.
- R2: `hit` is registered and reflects the address present in the previous cycle. It is 1 only when that line is valid and its stored tag equals the address tag. `eval_strobe` is high for exactly one cycle after a cycle in which the address differed from the address of the cycle before.
- R3: `rd_data` is registered and shows the stored word at the previous cycle's index and offset. A write in the same edge is seen one cycle later.
- R4: A write that hits stores `acc_wdata` and sets that line's modified bit. A write that misses changes no data and no tag state.
- R5: A fill request accepted while the block is idle captures the index and tag of `acc_addr` and invalidates that line. Fill words are then written at offsets 0 to 127 in order. `fill_ready` is high during the fill except in cycles where a processor write hits.
- R6: In the same edge that accepts the 128th fill word, the captured tag is written, valid is set and modified is cleared. Before that edge, the line does not hit.
- R7: After an access that misses on a line that is valid and modified, `vic_dirty` is 1 and `vic_tag` holds the stored tag. A miss on a clean or invalid line gives `vic_dirty` = 0.
- R8: A flush visits lines in ascending index order. For each valid line it holds `rep_valid` with `rep_idx`, `rep_tag` and `rep_dirty` (the modified bit) until `rep_ready`. Invalid lines are skipped. `busy` falls after the last line.
- R9: `init` takes precedence over all other inputs. It clears every valid and modified bit and the `hit` output, and it aborts a running fill or flush.
- R10: Fill and flush requests arriving while `busy` is high are ignored. If both requests arrive in the same idle cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Clear all tag state and the hit indication |
| acc_addr | input | ADDR_W | Processor word address |
| acc_wr | input | 1 | Processor write enable |
| acc_wdata | input | WORD_W | Processor write data |
| rd_data | output | WORD_W | Registered read data |
| hit | output | 1 | Registered hit result |
| eval_strobe | output | 1 | One-cycle pulse after an address change |
| vic_dirty | output | 1 | Miss on a valid, modified resident line |
| vic_tag | output | TAG_W | Tag of the resident line at the accessed index |
| fill_req | input | 1 | Start a line fill for the line of acc_addr |
| fill_valid | input | 1 | Fill word valid |
| fill_ready | output | 1 | Fill word accepted this cycle |
| fill_data | input | WORD_W | Fill word |
| flush_req | input | 1 | Start a flush walk |
| rep_valid | output | 1 | Flush report valid |
| rep_ready | input | 1 | Flush report taken |
| rep_idx | output | IDX_W | Line index of the report |
| rep_tag | output | TAG_W | Stored tag of the reported line |
| rep_dirty | output | 1 | Modified bit of the reported line |
| busy | output | 1 | Fill or flush in progress |

## Verification
A corrupted valid, tag or modified bit shows at the ports one cycle after the affected line is next addressed. It appears as a wrong `hit` or `vic_dirty`, or as a wrong report during a flush. The bench therefore reads each line back after every fill, write and clear. A fill-counter fault shows as data at the wrong offset on the next read, or as a commit too early or too late. The bench catches this by checking that `hit` stays low in the cycle after the final word and rises in the next one. Walker faults show within a few cycles as a missing, duplicated or unheld report.

// File: rtl/l1tc_pkg.sv
package l1tc_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/l1tc_tag_store.sv
module l1tc_tag_store #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_mod,
  output logic [TAG_W-1:0] lk_tag,
  input  logic [IDX_W-1:0] wk_idx,
  output logic             wk_valid,
  output logic             wk_mod,
  output logic [TAG_W-1:0] wk_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] ent_valid;
  logic [LINES-1:0] ent_mod;
  logic [TAG_W-1:0] ent_tag [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_mod   <= '0;
      for (int i = 0; i < LINES; i++) ent_tag[i] <= '0;
    end else if (init) begin
      ent_valid <= '0;
      ent_mod   <= '0;
      for (int i = 0; i < LINES; i++) ent_tag[i] <= '0;
    end else begin
      if (mark_en) ent_mod[mark_idx] <= 1'b1;
      if (commit_en) begin
        ent_valid[commit_idx] <= 1'b1;
        ent_mod[commit_idx]   <= 1'b0;
        ent_tag[commit_idx]   <= commit_tag;
      end
      if (inv_en) begin
        ent_valid[inv_idx] <= 1'b0;
        ent_mod[inv_idx]   <= 1'b0;
      end
    end
  end

  assign lk_valid = ent_valid[lk_idx];
  assign lk_mod   = ent_mod[lk_idx];
  assign lk_tag   = ent_tag[lk_idx];
  assign wk_valid = ent_valid[wk_idx];
  assign wk_mod   = ent_mod[wk_idx];
  assign wk_tag   = ent_tag[wk_idx];

  p_commit_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && !init && !(inv_en && inv_idx == commit_idx)
      |=> ent_valid[$past(commit_idx)] && !ent_mod[$past(commit_idx)]);

  p_init_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> ent_valid == '0 && ent_mod == '0);

  p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && !init |=> !ent_valid[$past(inv_idx)]);
endmodule

// File: rtl/l1tc_data_ram.sv
module l1tc_data_ram #(
  parameter int unsigned AW     = 9,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/l1tc_flush_walker.sv
module l1tc_flush_walker
  import l1tc_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             ent_valid,
  input  logic             rep_ready,
  output logic [IDX_W-1:0] walk_idx,
  output logic             rep_valid,
  output logic             walking
);
  localparam logic [IDX_W-1:0] LAST = '1;

  walk_state_e state;
  logic        advance;

  assign walking   = (state == WALK_RUN);
  assign rep_valid = walking && ent_valid;
  assign advance   = walking && (!ent_valid || rep_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WALK_IDLE;
      walk_idx <= '0;
    end else if (abort) begin
      state    <= WALK_IDLE;
      walk_idx <= '0;
    end else if (start && !walking) begin
      state    <= WALK_RUN;
      walk_idx <= '0;
    end else if (advance) begin
      if (walk_idx == LAST) begin
        state    <= WALK_IDLE;
        walk_idx <= '0;
      end else begin
        walk_idx <= walk_idx + 1'b1;
      end
    end
  end

  p_report_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready && !abort |=> rep_valid && $stable(walk_idx));
endmodule

// File: rtl/l1_tag_ctrl.sv
module l1_tag_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_WORDS = 128,
  parameter int unsigned LINES      = 4,
  localparam int unsigned OFFS_W    = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(LINES),
  localparam int unsigned TAG_W     = ADDR_W - OFFS_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              hit,
  output logic              eval_strobe,
  output logic              vic_dirty,
  output logic [TAG_W-1:0]  vic_tag,
  input  logic              fill_req,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              flush_req,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [IDX_W-1:0]  rep_idx,
  output logic [TAG_W-1:0]  rep_tag,
  output logic              rep_dirty,
  output logic              busy
);
  localparam int unsigned RAM_AW = IDX_W + OFFS_W;
  localparam logic [OFFS_W-1:0] LAST_OFF = OFFS_W'(LINE_WORDS - 1);

  logic [OFFS_W-1:0] a_off;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  assign a_off = acc_addr[OFFS_W-1:0];
  assign a_idx = acc_addr[OFFS_W +: IDX_W];
  assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];

  logic             lk_valid, lk_mod, lk_hit;
  logic [TAG_W-1:0] lk_tag;
  logic             wk_valid;
  logic [IDX_W-1:0] wk_idx;

  logic              fill_act;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [OFFS_W-1:0] fill_cnt;
  logic              walking;

  logic cpu_we, beat, last_beat, start_fill, start_flush;

  assign lk_hit      = lk_valid && (lk_tag == a_tag);
  assign cpu_we      = acc_wr && lk_hit;
  assign fill_ready  = fill_act && !cpu_we;
  assign beat        = fill_valid && fill_ready;
  assign last_beat   = beat && (fill_cnt == LAST_OFF);
  assign busy        = fill_act || walking;
  assign start_fill  = fill_req && !busy && !init;
  assign start_flush = flush_req && !busy && !init && !fill_req;

  l1tc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .init(init),
    .lk_idx(a_idx), .lk_valid(lk_valid), .lk_mod(lk_mod), .lk_tag(lk_tag),
    .wk_idx(wk_idx), .wk_valid(wk_valid), .wk_mod(rep_dirty), .wk_tag(rep_tag),
    .inv_en(start_fill), .inv_idx(a_idx),
    .commit_en(last_beat && !init), .commit_idx(fill_idx), .commit_tag(fill_tag),
    .mark_en(cpu_we && !init), .mark_idx(a_idx)
  );

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [WORD_W-1:0] ram_wdata;
  assign ram_we    = cpu_we || beat;
  assign ram_waddr = cpu_we ? {a_idx, a_off} : {fill_idx, fill_cnt};
  assign ram_wdata = cpu_we ? acc_wdata : fill_data;

  l1tc_data_ram #(.AW(RAM_AW), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr({a_idx, a_off}), .rdata(rd_data)
  );

  l1tc_flush_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort(init), .start(start_flush),
    .ent_valid(wk_valid), .rep_ready(rep_ready),
    .walk_idx(wk_idx), .rep_valid(rep_valid), .walking(walking)
  );
  assign rep_idx = wk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_act <= 1'b0;
      fill_idx <= '0;
      fill_tag <= '0;
      fill_cnt <= '0;
    end else if (init) begin
      fill_act <= 1'b0;
      fill_cnt <= '0;
    end else if (start_fill) begin
      fill_act <= 1'b1;
      fill_idx <= a_idx;
      fill_tag <= a_tag;
      fill_cnt <= '0;
    end else if (beat) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (last_beat) fill_act <= 1'b0;
    end
  end

  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      hit         <= 1'b0;
      eval_strobe <= 1'b0;
      vic_dirty   <= 1'b0;
      vic_tag     <= '0;
    end else begin
      addr_q      <= acc_addr;
      eval_strobe <= (acc_addr != addr_q);
      vic_tag     <= lk_tag;
      if (init) begin
        hit       <= 1'b0;
        vic_dirty <= 1'b0;
      end else begin
        hit       <= lk_hit;
        vic_dirty <= lk_valid && lk_mod && !lk_hit;
      end
    end
  end

  p_victim_excludes_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vic_dirty |-> !hit);

  p_no_ready_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fill_ready && !rep_valid);
endmodule

// File: tb/sim_l1_tag_ctrl.sv
module sim_l1_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        hit, eval_strobe, vic_dirty;
  logic [6:0]  vic_tag;
  logic        fill_req = 1'b0, fill_valid = 1'b0, fill_ready;
  logic [31:0] fill_data = '0;
  logic        flush_req = 1'b0, rep_valid, rep_ready = 1'b0;
  logic [1:0]  rep_idx;
  logic [6:0]  rep_tag;
  logic        rep_dirty, busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  l1_tag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .hit(hit), .eval_strobe(eval_strobe),
    .vic_dirty(vic_dirty), .vic_tag(vic_tag), .fill_req(fill_req),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .flush_req(flush_req), .rep_valid(rep_valid), .rep_ready(rep_ready),
    .rep_idx(rep_idx), .rep_tag(rep_tag), .rep_dirty(rep_dirty), .busy(busy)
  );

  function automatic logic [15:0] mk(input int t, input int i, input int o);
    return {t[6:0], i[1:0], o[6:0]};
  endfunction

  function automatic logic [31:0] pat(input int t, input int i, input int o);
    return {8'hA5, 1'b0, t[6:0], 6'd0, i[1:0], 1'b0, o[6:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic goto(input int t, input int i, input int o);
    @(negedge clk);
    acc_addr = mk(t, i, o);
    @(negedge clk);
  endtask

  // mode 0: plain, 1: CPU write hit mid-fill, 2: probe old tag and flush request mid-fill
  task automatic do_fill(input int t, input int i, input int mode);
    int k = 0;
    int it = 0;
    @(negedge clk);
    acc_addr = mk(t, i, 0);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    chk(busy == 1'b1, "R5", "busy during fill", {31'd0, busy}, 32'd1);
    while (k < 128 && it < 1000) begin
      fill_valid = (it % 37 != 36);
      fill_data  = pat(t, i, k);
      if (mode == 1 && it == 10) begin
        acc_addr = mk(5, 1, 9);
        acc_wr = 1'b1;
        acc_wdata = 32'hBEEF_0009;
        #1;
        chk(fill_ready == 1'b0, "R5", "ready low on write hit", {31'd0, fill_ready}, 32'd0);
      end
      if (mode == 2 && it == 20) begin
        acc_addr = mk(5, 1, 3);
        flush_req = 1'b1;
      end
      if (mode == 2 && it == 21) begin
        chk(hit == 1'b0, "R5", "refilled line invalidated", {31'd0, hit}, 32'd0);
        flush_req = 1'b0;
      end
      #1;
      if (fill_valid && fill_ready) k++;
      it++;
      @(negedge clk);
      acc_wr = 1'b0;
      acc_addr = mk(t, i, 0);
    end
    fill_valid = 1'b0;
    chk(hit == 1'b0, "R6", "no hit before commit visible", {31'd0, hit}, 32'd0);
    @(negedge clk);
    chk(hit == 1'b1, "R6", "hit after fill", {31'd0, hit}, 32'd1);
    chk(busy == 1'b0, "R10", "idle after fill", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset;
    chk(hit == 1'b0, "R2", "reset hit", {31'd0, hit}, 32'd0);
    chk(eval_strobe == 1'b0, "R2", "reset strobe", {31'd0, eval_strobe}, 32'd0);
    chk(busy == 1'b0 && rep_valid == 1'b0, "R8", "reset idle", {30'd0, busy, rep_valid}, 32'd0);
  endtask

  task automatic t_miss;
    goto(5, 1, 3);
    chk(eval_strobe == 1'b1, "R2", "strobe on change", {31'd0, eval_strobe}, 32'd1);
    chk(hit == 1'b0, "R2", "cold miss", {31'd0, hit}, 32'd0);
    chk(vic_dirty == 1'b0, "R7", "no victim on invalid", {31'd0, vic_dirty}, 32'd0);
    @(negedge clk);
    chk(eval_strobe == 1'b0, "R2", "strobe one cycle", {31'd0, eval_strobe}, 32'd0);
  endtask

  task automatic t_read;
    goto(5, 1, 77);
    chk(eval_strobe == 1'b1 && hit == 1'b1, "R2", "hit with strobe", {30'd0, eval_strobe, hit}, 32'd3);
    chk(rd_data == pat(5, 1, 77), "R3", "read offset 77", rd_data, pat(5, 1, 77));
    goto(5, 1, 0);
    chk(rd_data == pat(5, 1, 0), "R1", "read offset 0", rd_data, pat(5, 1, 0));
    goto(5, 1, 127);
    chk(rd_data == pat(5, 1, 127), "R1", "read offset 127", rd_data, pat(5, 1, 127));
  endtask

  task automatic t_write_and_victim;
    @(negedge clk);
    acc_addr = mk(5, 1, 3);
    acc_wr = 1'b1;
    acc_wdata = 32'h1234_5678;
    @(negedge clk);
    acc_wr = 1'b0;
    @(negedge clk);
    chk(rd_data == 32'h1234_5678, "R4", "write hit stored", rd_data, 32'h1234_5678);
    goto(9, 1, 3);
    chk(hit == 1'b0 && vic_dirty == 1'b1, "R7", "dirty victim flag", {30'd0, hit, vic_dirty}, 32'd1);
    chk(vic_tag == 7'd5, "R7", "victim tag", {25'd0, vic_tag}, 32'd5);
    @(negedge clk);
    acc_wr = 1'b1;
    acc_wdata = 32'hDEAD_0000;
    @(negedge clk);
    acc_wr = 1'b0;
    goto(5, 1, 3);
    chk(hit == 1'b1 && rd_data == 32'h1234_5678, "R4", "write miss ignored", rd_data, 32'h1234_5678);
  endtask

  task automatic t_clean_victim;
    do_fill(3, 2, 1);
    goto(4, 2, 0);
    chk(vic_dirty == 1'b0 && hit == 1'b0, "R7", "clean line no victim", {30'd0, hit, vic_dirty}, 32'd0);
    chk(vic_tag == 7'd3, "R7", "clean line tag shown", {25'd0, vic_tag}, 32'd3);
    goto(5, 1, 9);
    chk(rd_data == 32'hBEEF_0009, "R4", "write during fill", rd_data, 32'hBEEF_0009);
  endtask

  task automatic t_flush;
    int n = 0;
    int got = 0;
    logic [1:0] i2 = '0;
    logic [6:0] t2 = '0;
    logic d2 = 1'b0;
    @(negedge clk);
    flush_req = 1'b1;
    rep_ready = 1'b0;
    @(negedge clk);
    flush_req = 1'b0;
    while (!rep_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(rep_valid && rep_idx == 2'd1 && rep_tag == 7'd5 && rep_dirty,
        "R8", "first report line1", {22'd0, rep_valid, rep_idx, rep_tag, rep_dirty}, {22'd0, 1'b1, 2'd1, 7'd5, 1'b1});
    @(negedge clk);
    chk(rep_valid && rep_idx == 2'd1, "R8", "report held", {29'd0, rep_valid, rep_idx}, {29'd0, 1'b1, 2'd1});
    rep_ready = 1'b1;
    n = 0;
    while (busy && n < 20) begin
      if (rep_valid) begin
        got++;
        if (got == 2) begin
          i2 = rep_idx;
          t2 = rep_tag;
          d2 = rep_dirty;
        end
      end
      @(negedge clk);
      n++;
    end
    rep_ready = 1'b0;
    chk(got == 2, "R8", "valid line count", got, 32'd2);
    chk(i2 == 2'd2 && t2 == 7'd3 && d2 == 1'b0, "R8", "second report line2",
        {22'd0, i2, t2, d2}, {22'd0, 2'd2, 7'd3, 1'b0});
    chk(busy == 1'b0, "R8", "walk ends", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_refill;
    do_fill(6, 1, 2);
    chk(rep_valid == 1'b0, "R10", "flush during fill ignored", {31'd0, rep_valid}, 32'd0);
    goto(5, 1, 3);
    chk(hit == 1'b0 && vic_dirty == 1'b0, "R6", "refill clears modified", {30'd0, hit, vic_dirty}, 32'd0);
    chk(vic_tag == 7'd6, "R6", "new tag stored", {25'd0, vic_tag}, 32'd6);
  endtask

  task automatic t_init;
    int n = 0;
    int got = 0;
    goto(6, 1, 0);
    chk(hit == 1'b1, "R9", "hit before init", {31'd0, hit}, 32'd1);
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk(hit == 1'b0, "R9", "hit cleared by init", {31'd0, hit}, 32'd0);
    @(negedge clk);
    chk(hit == 1'b0, "R9", "line invalid after init", {31'd0, hit}, 32'd0);
    goto(3, 2, 0);
    chk(hit == 1'b0, "R9", "other line invalid", {31'd0, hit}, 32'd0);
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    fill_req = 1'b1;
    while (busy && n < 20) begin
      if (rep_valid) got++;
      @(negedge clk);
      fill_req = 1'b0;
      n++;
    end
    chk(got == 0, "R9", "no reports after init", got, 32'd0);
    chk(busy == 1'b0, "R10", "fill during flush ignored", {31'd0, busy}, 32'd0);
    @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk(busy == 1'b0 && fill_ready == 1'b0, "R9", "fill aborted", {30'd0, busy, fill_ready}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    do_fill(5, 1, 0);
    t_read();
    t_write_and_victim();
    t_clean_victim();
    t_flush();
    t_refill();
    t_init();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule